// File: doc/BRIEF.md
# Bit-Serial HDLC Frame Transmitter with Underrun-Terminated Frames

This block turns a stream of bytes delivered over a request/acknowledge handshake into a bit-serial HDLC-style line signal. While no data is waiting it fills the line with flag octets. When a byte is waiting at a flag boundary it opens a frame and shifts the bytes out, least significant bit first, one bit on each cycle that carries the transmit clock enable. Inside the frame it inserts a 0 after every run of five 1s.

The frame has no length field. It ends when the byte source runs dry. At the byte boundary where no byte is waiting, an end-of-frame latch decides how the frame is closed. If host software has cleared the latch with a command write, the block appends a 16-bit frame check sequence and a closing flag. If the latch is still set, it sends an abort run of ones instead. Both kinds of underrun set the latch again. Software therefore re-arms the latch once for each frame that should end cleanly. A two-part message, for example a length frame and then a data frame, is sent as two armed frames with flags between them.

Top module: `sdlc_frame_tx`

## Requirements
- R1: While reset is active and after it is released, `tx_bit` is 1, `dma_req` is 1 and `buf_empty` is 1. The end-of-frame latch comes out of reset set, so an underrun before any command write produces an abort.
- R2: While no frame is in progress the line carries back-to-back flags (0x7E, LSB first). Every frame starts only at the end of a complete flag, and the closing flag or the flag after an abort always precedes the next frame.
- R3: `dma_req` is high exactly while the one-byte holding buffer is empty. A byte on `dma_data` is accepted on a clock edge where `dma_ack` and `dma_req` are both high. `dma_ack` while `dma_req` is low has no effect.
- R4: Frame bytes are sent LSB first, one bit per `bit_en` cycle. At each byte boundary of a frame, the waiting byte is taken from the holding buffer.
- R5: In data and check-sequence bits, a 0 is sent after every five consecutive 1s, and this includes runs that cross a byte or field boundary. No 0 is inserted inside flags or abort runs.
- R6: If the latch is clear at an underrun, the block sends the ones' complement of a CRC-16 over the frame's data bits. The CRC uses the reflected polynomial 0x8408 and is preset to 0xFFFF. It is sent LSB first, then a flag, and the latch becomes set.
- R7: If the latch is already set at an underrun, the block sends eight 1 bits and then a flag, and then returns to idle flags.
- R8: A command write (`cmd_we` high) with `cmd_data` equal to 0xC0 clears the latch. A command write with any other value leaves the latch unchanged. An underrun in the same cycle takes priority and sets the latch.
- R9: `buf_empty` is 1 while the holding buffer has no byte and drops to 0 once a byte has been accepted.
- R10: `tx_bit` changes only on clock edges where `bit_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Transmit clock enable: one line bit per high cycle |
| dma_req | output | 1 | Holding buffer can accept a byte |
| dma_ack | input | 1 | Byte on `dma_data` is being delivered |
| dma_data | input | 8 | Byte delivered with `dma_ack` |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command value; 0xC0 clears the end-of-frame latch |
| tx_bit | output | 1 | Serial line output |
| buf_empty | output | 1 | Holding buffer empty status |

## Verification
The hardest condition to reach is a run of five 1s that ends exactly on a boundary: the last data bit before the check sequence, or the end of a byte, with the check sequence itself then starting with 1s. Reaching it depends on the data values and also on the check value those data produce. The stimulus sends frames built from 0xFF, 0xF8, 0x1F and 0x3F bytes, under both random and full-rate `bit_en`, in armed, unarmed and wrongly-commanded frames. A behavioural model in the bench keeps its own bit queue and CRC, and it is compared with the design on every clock.

// File: rtl/sdlc_tx_pkg.sv
package sdlc_tx_pkg;

  typedef enum logic [1:0] {
    FLD_FLAG = 2'd0,
    FLD_DATA = 2'd1,
    FLD_FCS  = 2'd2,
    FLD_MARK = 2'd3
  } fld_e;

  localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
  localparam logic [7:0]  ARM_CMD    = 8'hC0;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;

endpackage

// File: rtl/sdlc_tx_buf.sv
module sdlc_tx_buf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          ack,
  input  logic [DW-1:0] din,
  input  logic          take,
  output logic          req,
  output logic          full,
  output logic [DW-1:0] dout
);

  logic          full_q, full_d;
  logic [DW-1:0] data_q, data_d;
  logic          accept;

  always_comb begin
    accept = ack && !full_q;
    full_d = full_q;
    data_d = data_q;
    if (accept) begin
      full_d = 1'b1;
      data_d = din;
    end else if (take) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      data_q <= data_d;
    end
  end

  assign req  = !full_q;
  assign full = full_q;
  assign dout = data_q;

  // R3: an acknowledged request fills the buffer
  assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (ack && req) |=> full);

  // R4: the serializer only takes a byte that is present
  assert_take_full_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    take |-> full_q);

endmodule

// File: rtl/sdlc_crc_acc.sv
module sdlc_crc_acc #(
  parameter int          CW     = 16,
  parameter logic [15:0] POLY   = 16'h8408,
  parameter logic [15:0] PRESET = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          restart,
  input  logic          bit_vld,
  input  logic          bit_in,
  output logic [CW-1:0] crc_q
);

  localparam logic [CW-1:0] POLY_W   = CW'(POLY);
  localparam logic [CW-1:0] PRESET_W = CW'(PRESET);

  logic [CW-1:0] acc_q, acc_d, base;
  logic          fb;

  always_comb begin
    base  = restart ? PRESET_W : acc_q;
    fb    = base[0] ^ bit_in;
    acc_d = acc_q;
    if (bit_vld) begin
      acc_d = {1'b0, base[CW-1:1]} ^ (fb ? POLY_W : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) acc_q <= PRESET_W;
    else         acc_q <= acc_d;
  end

  assign crc_q = acc_q;

endmodule

// File: rtl/sdlc_tx_ser.sv
module sdlc_tx_ser
  import sdlc_tx_pkg::*;
#(
  parameter int DW        = 8,
  parameter int CW        = 16,
  parameter int STUFF_RUN = 5
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          bit_en,
  input  logic          buf_full,
  input  logic [DW-1:0] buf_data,
  input  logic          latch_q,
  input  logic [CW-1:0] crc_q,
  output logic          take,
  output logic          urun,
  output logic          crc_restart,
  output logic          crc_vld,
  output logic          crc_bit,
  output logic          tx_bit
);

  localparam int CNTW = $clog2(CW + 1);
  localparam int OW   = $clog2(STUFF_RUN + 2);
  localparam logic [CW-1:0]   FLAG_FIELD = CW'(FLAG_BYTE);
  localparam logic [CW-1:0]   MARK_FIELD = CW'({DW{1'b1}});
  localparam logic [CNTW-1:0] BYTE_BITS  = CNTW'(DW);
  localparam logic [CNTW-1:0] FCS_BITS   = CNTW'(CW);
  localparam logic [OW-1:0]   RUN_LIMIT  = OW'(STUFF_RUN);

  fld_e            kind_q, kind_d, sel_kind;
  logic [CW-1:0]   sh_q, sh_d, sel_sh;
  logic [CNTW-1:0] cnt_q, cnt_d, sel_cnt;
  logic [OW-1:0]   ones_q, ones_d;
  logic            tx_q, tx_d;
  logic            stuff_now, go;
  logic            want_take, want_urun, want_restart;

  // field selection: continue the current field or pick the next one
  always_comb begin
    stuff_now    = ((kind_q == FLD_DATA) || (kind_q == FLD_FCS)) && (ones_q == RUN_LIMIT);
    go           = bit_en && !stuff_now;
    sel_kind     = kind_q;
    sel_sh       = sh_q;
    sel_cnt      = cnt_q;
    want_take    = 1'b0;
    want_urun    = 1'b0;
    want_restart = 1'b0;
    if (cnt_q == '0) begin
      unique case (kind_q)
        FLD_FLAG: begin
          if (buf_full) begin
            sel_kind     = FLD_DATA;
            sel_sh       = CW'(buf_data);
            sel_cnt      = BYTE_BITS;
            want_take    = 1'b1;
            want_restart = 1'b1;
          end else begin
            sel_kind = FLD_FLAG;
            sel_sh   = FLAG_FIELD;
            sel_cnt  = BYTE_BITS;
          end
        end
        FLD_DATA: begin
          if (buf_full) begin
            sel_kind  = FLD_DATA;
            sel_sh    = CW'(buf_data);
            sel_cnt   = BYTE_BITS;
            want_take = 1'b1;
          end else if (!latch_q) begin
            sel_kind  = FLD_FCS;
            sel_sh    = ~crc_q;
            sel_cnt   = FCS_BITS;
            want_urun = 1'b1;
          end else begin
            sel_kind  = FLD_MARK;
            sel_sh    = MARK_FIELD;
            sel_cnt   = BYTE_BITS;
            want_urun = 1'b1;
          end
        end
        default: begin
          sel_kind = FLD_FLAG;
          sel_sh   = FLAG_FIELD;
          sel_cnt  = BYTE_BITS;
        end
      endcase
    end
  end

  assign take        = go && want_take;
  assign urun        = go && want_urun;
  assign crc_restart = go && want_restart;
  assign crc_vld     = go && (sel_kind == FLD_DATA);
  assign crc_bit     = sel_sh[0];

  // next-state for the shifter, counters and line bit
  always_comb begin
    kind_d = kind_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    ones_d = ones_q;
    tx_d   = tx_q;
    if (bit_en) begin
      if (stuff_now) begin
        ones_d = '0;
        tx_d   = 1'b0;
      end else begin
        kind_d = sel_kind;
        sh_d   = sel_sh >> 1;
        cnt_d  = sel_cnt - 1'b1;
        tx_d   = sel_sh[0];
        if (((sel_kind == FLD_DATA) || (sel_kind == FLD_FCS)) && sel_sh[0])
          ones_d = ones_q + 1'b1;
        else
          ones_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= FLD_MARK;
      sh_q   <= '0;
      cnt_q  <= '0;
      ones_q <= '0;
      tx_q   <= 1'b1;
    end else begin
      kind_q <= kind_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      ones_q <= ones_d;
      tx_q   <= tx_d;
    end
  end

  assign tx_bit = tx_q;

  // R5: the run of stuffable ones never passes the insertion limit
  assert_run_limit_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    ones_q <= RUN_LIMIT);

  // R10: the line holds its value between enables
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    !bit_en |=> $stable(tx_bit));

endmodule

// File: rtl/sdlc_frame_tx.sv
module sdlc_frame_tx
  import sdlc_tx_pkg::*;
#(
  parameter int DW        = 8,
  parameter int CW        = 16,
  parameter int STUFF_RUN = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  output logic          dma_req,
  input  logic          dma_ack,
  input  logic [DW-1:0] dma_data,
  input  logic          cmd_we,
  input  logic [7:0]    cmd_data,
  output logic          tx_bit,
  output logic          buf_empty
);

  logic          rs1_q, rst_ni;
  logic          buf_full, take, urun, crc_restart, crc_vld, crc_bit;
  logic [DW-1:0] buf_data;
  logic [CW-1:0] crc_q;
  logic          latch_q, latch_d, arm_cmd;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q  <= 1'b0;
      rst_ni <= 1'b0;
    end else begin
      rs1_q  <= 1'b1;
      rst_ni <= rs1_q;
    end
  end

  sdlc_tx_buf #(.DW(DW)) u_buf (
    .clk    (clk),
    .rst_ni (rst_ni),
    .ack    (dma_ack),
    .din    (dma_data),
    .take   (take),
    .req    (dma_req),
    .full   (buf_full),
    .dout   (buf_data)
  );

  sdlc_crc_acc #(.CW(CW), .POLY(CRC_POLY_R), .PRESET(CRC_PRESET)) u_crc (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .restart (crc_restart),
    .bit_vld (crc_vld),
    .bit_in  (crc_bit),
    .crc_q   (crc_q)
  );

  sdlc_tx_ser #(.DW(DW), .CW(CW), .STUFF_RUN(STUFF_RUN)) u_ser (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .bit_en      (bit_en),
    .buf_full    (buf_full),
    .buf_data    (buf_data),
    .latch_q     (latch_q),
    .crc_q       (crc_q),
    .take        (take),
    .urun        (urun),
    .crc_restart (crc_restart),
    .crc_vld     (crc_vld),
    .crc_bit     (crc_bit),
    .tx_bit      (tx_bit)
  );

  // end-of-frame latch: set by any underrun, cleared by the arm command
  always_comb begin
    arm_cmd = cmd_we && (cmd_data == ARM_CMD);
    latch_d = latch_q;
    if (urun)         latch_d = 1'b1;
    else if (arm_cmd) latch_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) latch_q <= 1'b1;
    else         latch_q <= latch_d;
  end

  assign buf_empty = !buf_full;

  // R8: the arm command clears the latch when no underrun competes
  assert_arm_clear_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_we && (cmd_data == ARM_CMD) && !urun) |=> !latch_q);

  // R6: every underrun leaves the latch set
  assert_urun_sets_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    urun |=> latch_q);

endmodule

// File: tb/sim_sdlc_frame_tx.sv
module sim_sdlc_frame_tx;

  logic       clk;
  logic       rst_n;
  logic       bit_en;
  logic       dma_req;
  logic       dma_ack;
  logic [7:0] dma_data;
  logic       cmd_we;
  logic [7:0] cmd_data;
  logic       tx_bit;
  logic       buf_empty;

  sdlc_frame_tx u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .dma_req   (dma_req),
    .dma_ack   (dma_ack),
    .dma_data  (dma_data),
    .cmd_we    (cmd_we),
    .cmd_data  (cmd_data),
    .tx_bit    (tx_bit),
    .buf_empty (buf_empty)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  // stimulus controls
  bit         en_full   = 0;
  bit         stray_on  = 0;
  logic [7:0] feed_q[$];

  // reference model state
  bit         r1 = 0, r2 = 0;
  bit         m_full;
  logic [7:0] m_buf;
  bit         m_latch;
  int         m_ones;
  int         m_kind;   // 0 flag, 1 data, 2 check sequence, 3 ones run
  bit         m_q[$];
  logic [15:0] m_crc;
  bit         m_tx;
  string      m_tag;
  bit         m_prev_en;
  int         m_ends;

  task automatic push_flag();
    for (int i = 0; i < 8; i++) m_q.push_back(((8'h7E >> i) & 8'h01) != 0);
    m_kind = 0;
  endtask

  task automatic push_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) m_q.push_back(v[i]);
    m_kind = 1;
  endtask

  always @(posedge clk) begin
    bit old_full, urun_now, b, active;
    active = r2;
    r2 = r1;
    r1 = rst_n;
    if (!rst_n) begin
      r1 = 0; r2 = 0;
    end
    m_prev_en = bit_en;
    if (!rst_n || !active) begin
      m_full = 0; m_buf = 0; m_latch = 1; m_ones = 0; m_kind = 3;
      m_q.delete(); m_crc = 16'hFFFF; m_tx = 1; m_tag = "R1"; m_prev_en = 0;
    end else begin
      old_full = m_full;
      urun_now = 0;
      if (bit_en) begin
        if ((m_kind == 1 || m_kind == 2) && m_ones == 5) begin
          m_tx = 0; m_ones = 0; m_tag = "R5";
        end else begin
          if (m_q.size() == 0) begin
            case (m_kind)
              0: begin
                if (old_full) begin
                  push_byte(m_buf); m_full = 0; m_crc = 16'hFFFF;
                end else push_flag();
              end
              1: begin
                if (old_full) begin
                  push_byte(m_buf); m_full = 0;
                end else if (!m_latch) begin
                  for (int i = 0; i < 16; i++) m_q.push_back(~m_crc[i]);
                  m_kind = 2; m_latch = 1; urun_now = 1; m_ends++;
                end else begin
                  for (int i = 0; i < 8; i++) m_q.push_back(1'b1);
                  m_kind = 3; m_latch = 1; urun_now = 1; m_ends++;
                end
              end
              default: push_flag();
            endcase
          end
          b = m_q.pop_front();
          m_tx = b;
          if (m_kind == 1) begin
            bit fb;
            fb = m_crc[0] ^ b;
            m_crc = m_crc >> 1;
            if (fb) m_crc = m_crc ^ 16'h8408;
          end
          if ((m_kind == 1 || m_kind == 2) && b) m_ones++;
          else m_ones = 0;
          case (m_kind)
            0: m_tag = "R2";
            1: m_tag = "R4";
            2: m_tag = "R6,R8";
            default: m_tag = "R7,R8";
          endcase
        end
      end
      if (cmd_we && cmd_data == 8'hC0 && !urun_now) m_latch = 0;
      if (dma_ack && !old_full) begin
        m_full = 1; m_buf = dma_data;
      end
    end
  end

  task automatic check1(input string tag, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check1(m_prev_en ? m_tag : "R10", "tx_bit", tx_bit, m_tx);
      check1("R3", "dma_req", dma_req, !m_full);
      check1("R9", "buf_empty", buf_empty, !m_full);
    end
  end

  // stimulus drivers at the falling edge
  always @(negedge clk) begin
    bit_en <= en_full ? 1'b1 : ($urandom_range(0, 2) == 0);
    if (dma_req && feed_q.size() > 0) begin
      dma_ack  <= 1'b1;
      dma_data <= feed_q.pop_front();
    end else if (stray_on && !dma_req) begin
      dma_ack  <= ($urandom_range(0, 1) == 1);
      dma_data <= 8'($urandom);
    end else begin
      dma_ack  <= 1'b0;
      dma_data <= 8'($urandom);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_cmd(input logic [7:0] v);
    @(negedge clk);
    cmd_we   = 1'b1;
    cmd_data = v;
    @(negedge clk);
    cmd_we   = 1'b0;
    cmd_data = 8'h00;
  endtask

  task automatic wait_ends(input int n);
    while (m_ends < n) @(negedge clk);
    idle(300);
  endtask

  initial begin
    rst_n    = 1'b0;
    cmd_we   = 1'b0;
    cmd_data = 8'h00;
    m_ends   = 0;
    idle(4);
    // R1: reset values while reset is held
    check1("R1", "tx_bit in reset", tx_bit, 1'b1);
    check1("R1", "dma_req in reset", dma_req, 1'b1);
    check1("R1", "buf_empty in reset", buf_empty, 1'b1);
    rst_n = 1'b1;
    idle(3);
    check1("R1", "tx_bit after reset", tx_bit, 1'b1);
    // R2: idle flags only, with stray acknowledges while the buffer is full later
    idle(80);
    // R7: latch set out of reset, so this frame ends in an abort
    feed_q.push_back(8'hA5); feed_q.push_back(8'h3C); feed_q.push_back(8'hFF);
    wait_ends(1);
    // R8: a non-arm command value leaves the latch set -> abort again
    write_cmd(8'h55);
    write_cmd(8'h40);
    stray_on = 1;
    feed_q.push_back(8'h0F); feed_q.push_back(8'hF8);
    wait_ends(2);
    // R6 R5: armed frame with long runs of ones across byte boundaries
    write_cmd(8'hC0);
    feed_q.push_back(8'hFF); feed_q.push_back(8'h7E); feed_q.push_back(8'hF8);
    feed_q.push_back(8'h1F); feed_q.push_back(8'h00); feed_q.push_back(8'h3F);
    wait_ends(3);
    // R7: latch set again by the check-sequence underrun, no re-arm -> abort
    feed_q.push_back(8'h81);
    wait_ends(4);
    // R2 R4: length frame then data frame at full bit rate
    en_full = 1;
    write_cmd(8'hC0);
    feed_q.push_back(8'h05);
    wait_ends(5);
    write_cmd(8'hC0);
    feed_q.push_back(8'h11); feed_q.push_back(8'hFF); feed_q.push_back(8'hFF);
    feed_q.push_back(8'h80); feed_q.push_back(8'h3F);
    wait_ends(6);
    en_full = 0;
    // R6: a single-byte armed frame under random enables
    write_cmd(8'hC0);
    feed_q.push_back(8'hE7);
    wait_ends(7);
    stray_on = 0;
    idle(100);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule